// File: doc/BRIEF.md
# Positive-Only Power-to-Pulse Converter

This block turns a stream of signed real-power samples into two trains of pulse requests whose rates are proportional to positive power. Each accepted sample is added to two accumulators. Whenever an accumulator reaches its energy quantum, the quantum is taken off, any remainder is kept, and a one-cycle request is raised. The slow path drives counter or stepper outputs. The fast path drives a calibration output. Pulse-width shaping is done downstream.

Two rate-select inputs pick one of four slow quanta, each half the size of the one before it. A calibration-select input, together with the rate selects, fixes how many times faster the fast path runs. Samples that are negative or below a no-load (creep) level are never integrated. While an external negative-power flag is high, requests are dropped but the integration continues. A reverse indicator output copies that flag, and it changes only at the instants when the fast path would issue a pulse.

A small state machine classifies each valid sample. It has four states. LD_IDLE is the state after reset. LD_ACTIVE means the last sample was non-negative and at or above the creep level. LD_NOLOAD means the last sample was non-negative but below the creep level. LD_NEGATIVE means the last sample was negative. Every valid sample moves the machine to the state that matches its class, from any state. Without a valid sample the state holds. The machine registers the sample, so one is integrated only in the cycle after it was presented, and only when the state is LD_ACTIVE.

Top module: `pfc_pulse_conv`

## Requirements
- R1: During and right after reset, slow_req, fast_req and rev_out are 0 and both accumulators are empty.
- R2: A valid sample with the sign bit set adds nothing to either accumulator, so it does not move the timing of later pulses.
- R3: A valid non-negative sample whose value is below creep_min adds nothing to either accumulator.
- R4: The slow quantum is 2^(QB - s), where s = {rate_sel_hi, rate_sel_lo}. An accepted sample presented in cycle k raises slow_req for one cycle after edge k+1 if the slow sum reaches the quantum. The quantum is then subtracted and the remainder carries over.
- R5: The fast quantum is the slow quantum divided by 2^m. With cal_sel=1, m = 7 - s. With cal_sel=0, m = 6 - s, except that s=3 gives m = 11 (a 2048x ratio). The fast path otherwise behaves like R4.
- R6: Each path raises at most one single-cycle request per accepted sample, even when a sample exceeds the quantum. The excess stays in the accumulator.
- R7: No request is raised on either path at an edge where rev_flag is high. Integration still continues while it is high.
- R8: At each fast-path quantum crossing, rev_out takes the value of rev_flag. At all other times it holds its value.
- R9: A request appears only in the cycle after an integration step, so it never appears without a valid sample two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SW | Signed real-power sample |
| creep_min | input | SW | No-load level; samples below it are not integrated |
| rate_sel_lo | input | 1 | Rate select, low bit of s |
| rate_sel_hi | input | 1 | Rate select, high bit of s |
| cal_sel | input | 1 | Calibration-rate select |
| rev_flag | input | 1 | Negative-power flag; inhibits requests |
| slow_req | output | 1 | Slow-path pulse request strobe |
| fast_req | output | 1 | Fast-path pulse request strobe |
| rev_out | output | 1 | Reverse indicator, updated at fast crossings |

## Verification
The bench targets long runs of negative and sub-creep samples, followed by the exact number of good samples needed for the first crossing. A design that let either kind of sample leak into the accumulator would pulse too early, or pulse during the run itself. All eight select combinations are swept at a fixed load. A wrong multiplier, including a missing 2048x special case, shows up as a wrong pulse count. The reverse phase checks that requests vanish while rev_out rises and later falls only at fast crossings. A design that dropped the remainder, or issued several pulses for one oversized sample, would drift from the per-cycle model.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        LD_IDLE,
        LD_ACTIVE,
        LD_NOLOAD,
        LD_NEGATIVE
    } load_state_e;

    // log2 of the fast-to-slow rate ratio for a rate/calibration selection
    function automatic int fast_log2_ratio(input logic [1:0] rate_sel, input logic cal_sel);
        int r;
        if (!cal_sel && rate_sel == 2'd3)
            r = 11;
        else if (cal_sel)
            r = 7 - int'(rate_sel);
        else
            r = 6 - int'(rate_sel);
        return r;
    endfunction

endpackage

// File: rtl/pfc_qualify.sv
module pfc_qualify
    import pfc_pkg::*;
#(
    parameter int SW = 16,
    localparam int MW = SW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp_data,
    input  logic        [SW-1:0] creep_min,
    output logic                 add_en,
    output logic        [MW-1:0] add_amt
);

    load_state_e state_q, state_d;
    logic        stb_q;
    logic [MW-1:0] amt_q;
    logic        below_creep;

    assign below_creep = {1'b0, smp_data[MW-1:0]} < creep_min;

    always_comb begin
        state_d = state_q;
        if (smp_valid) begin
            if (smp_data[SW-1])
                state_d = LD_NEGATIVE;
            else if (below_creep)
                state_d = LD_NOLOAD;
            else
                state_d = LD_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
            stb_q   <= 1'b0;
            amt_q   <= '0;
        end else begin
            state_q <= state_d;
            stb_q   <= smp_valid;
            if (smp_valid)
                amt_q <= smp_data[MW-1:0];
        end
    end

    always_comb begin
        add_en  = 1'b0;
        add_amt = amt_q;
        unique case (state_q)
            LD_IDLE:     add_en = 1'b0;
            LD_ACTIVE:   add_en = stb_q;
            LD_NOLOAD:   add_en = 1'b0;
            LD_NEGATIVE: add_en = 1'b0;
            default:     add_en = 1'b0;
        endcase
    end

    assert_neg_never_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_data[SW-1]) |=> !add_en);

    assert_creep_never_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_data[SW-1] && below_creep) |=> !add_en);

endmodule

// File: rtl/pfc_accum.sv
module pfc_accum #(
    parameter int AW = 32,
    parameter int MW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [MW-1:0] add_amt,
    input  logic [AW-1:0] quantum,
    input  logic          block,
    output logic          tick_c,
    output logic          req_o,
    output logic          evt_o
);

    logic [AW-1:0] acc_q;
    logic [AW:0]   sum_c;

    always_comb begin
        sum_c  = {1'b0, acc_q} + (AW+1)'(add_amt);
        tick_c = add_en && (sum_c >= {1'b0, quantum});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            req_o <= 1'b0;
            evt_o <= 1'b0;
        end else begin
            req_o <= tick_c && !block;
            evt_o <= tick_c;
            if (add_en)
                acc_q <= tick_c ? AW'(sum_c - {1'b0, quantum}) : sum_c[AW-1:0];
        end
    end

    assert_hold_without_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(acc_q));

    assert_req_follows_add_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(add_en));

endmodule

// File: rtl/pfc_pulse_conv.sv
module pfc_pulse_conv
    import pfc_pkg::*;
#(
    parameter int SW = 16,
    parameter int QB = 16,
    parameter int AW = 32,
    localparam int MW = SW - 1,
    localparam int NPATH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [SW-1:0] smp_data,
    input  logic        [SW-1:0] creep_min,
    input  logic                 rate_sel_lo,
    input  logic                 rate_sel_hi,
    input  logic                 cal_sel,
    input  logic                 rev_flag,
    output logic                 slow_req,
    output logic                 fast_req,
    output logic                 rev_out
);

    logic          add_en;
    logic [MW-1:0] add_amt;
    logic [1:0]    rate_sel;
    logic [AW-1:0] quanta [NPATH];
    logic [NPATH-1:0] tick_c, req_v, evt_v;
    logic          rev_q;

    assign rate_sel = {rate_sel_hi, rate_sel_lo};

    // index 0: slow path, index 1: fast path
    always_comb begin
        quanta[0] = AW'(1) << (QB - int'(rate_sel));
        quanta[1] = AW'(1) << (QB - int'(rate_sel) - fast_log2_ratio(rate_sel, cal_sel));
    end

    pfc_qualify #(.SW(SW)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .creep_min (creep_min),
        .add_en    (add_en),
        .add_amt   (add_amt)
    );

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        pfc_accum #(.AW(AW), .MW(MW)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (add_en),
            .add_amt (add_amt),
            .quantum (quanta[g]),
            .block   (rev_flag),
            .tick_c  (tick_c[g]),
            .req_o   (req_v[g]),
            .evt_o   (evt_v[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rev_q <= 1'b0;
        else if (tick_c[1])
            rev_q <= rev_flag;
    end

    assign slow_req = req_v[0];
    assign fast_req = req_v[1];
    assign rev_out  = rev_q;

    assert_no_pulse_in_reverse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_req || fast_req) |-> !$past(rev_flag));

    assert_rev_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_out != $past(rev_out)) |-> evt_v[1]);

    assert_one_cycle_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!slow_req && !fast_req && !rev_out) || !rst_n);

endmodule

// File: tb/tb_pfc_pulse_conv.sv
`timescale 1ns/1ps
module tb_pfc_pulse_conv;

    localparam int SW = 16;
    localparam int QB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [SW-1:0] smp_data = '0;
    logic [SW-1:0] creep_min = 16'd16;
    logic rate_sel_lo = 1'b0, rate_sel_hi = 1'b0, cal_sel = 1'b1, rev_flag = 1'b0;
    logic slow_req, fast_req, rev_out;

    always #5 clk = ~clk;

    pfc_pulse_conv #(.SW(SW), .QB(QB), .AW(32)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .creep_min(creep_min), .rate_sel_lo(rate_sel_lo), .rate_sel_hi(rate_sel_hi),
        .cal_sel(cal_sel), .rev_flag(rev_flag),
        .slow_req(slow_req), .fast_req(fast_req), .rev_out(rev_out)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int cnt_slow = 0, cnt_fast = 0;

    // behavioural reference
    longint m_sacc, m_facc;
    bit     m_pok;
    int     m_pamt;
    bit     e_slow, e_fast, e_rev;

    function automatic int ratio_log(int s, bit c);
        if (c) return 7 - s;
        if (s == 3) return 11;
        return 6 - s;
    endfunction

    function automatic longint slow_quant(int s);
        return longint'(1) << (QB - s);
    endfunction

    function automatic longint fast_quant(int s, bit c);
        return longint'(1) << (QB - s - ratio_log(s, c));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sacc = 0; m_facc = 0; m_pok = 0; m_pamt = 0;
            e_slow = 0; e_fast = 0; e_rev = 0;
        end else begin
            int s;
            s = {rate_sel_hi, rate_sel_lo};
            e_slow = 0; e_fast = 0;
            if (m_pok) begin
                m_sacc += m_pamt;
                if (m_sacc >= slow_quant(s)) begin m_sacc -= slow_quant(s); e_slow = !rev_flag; end
                m_facc += m_pamt;
                if (m_facc >= fast_quant(s, cal_sel)) begin
                    m_facc -= fast_quant(s, cal_sel); e_fast = !rev_flag; e_rev = rev_flag;
                end
            end
            m_pok  = smp_valid && (int'(smp_data) >= 0) && (int'(smp_data) >= int'(creep_min));
            m_pamt = int'(smp_data);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 slow_req per-cycle", slow_req, e_slow);
            check("R5 fast_req per-cycle", fast_req, e_fast);
            check("R8 rev_out per-cycle", rev_out, e_rev);
            cnt_slow += slow_req;
            cnt_fast += fast_req;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cnt_slow = 0; cnt_fast = 0;
    endtask

    task automatic feed(int val, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_data = SW'(val);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R6 watchdog expired actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 slow_req in reset", slow_req, 0);
        check("R1 fast_req in reset", fast_req, 0);
        check("R1 rev_out in reset", rev_out, 0);
        do_reset();
        @(negedge clk);
        check("R1 slow_req after reset", slow_req, 0);
        check("R1 rev_out after reset", rev_out, 0);

        // R4/R5: base mode, s=0, cal=1, 2000 samples of 300
        feed(300, 2000);
        check("R4 slow count s0", cnt_slow, 600000 / 65536);
        check("R5 fast count s0 cal1", cnt_fast, 600000 / 512);

        // R2: negative run, then exact samples to first crossing
        do_reset();
        feed(-3000, 500);
        check("R2 no pulses on negative input", cnt_slow + cnt_fast, 0);
        feed(300, 1);
        check("R2 accumulator untouched (1 sample)", cnt_fast, 0);
        feed(300, 1);
        check("R2 first crossing after 2 samples", cnt_fast, 1);

        // R3: creep
        do_reset();
        creep_min = 16'd16;
        feed(15, 1000);
        check("R3 no pulses below creep", cnt_slow + cnt_fast, 0);
        feed(16, 31);
        check("R3 no leak from sub-creep run", cnt_fast, 0);
        feed(16, 1);
        check("R3 crossing at exact quantum", cnt_fast, 1);

        // R5/R6: sweep all select combinations
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 4; s++) begin
                longint fq, expf, exps;
                rate_sel_hi = s[1]; rate_sel_lo = s[0]; cal_sel = c[0];
                do_reset();
                feed(64, 256);
                fq   = fast_quant(s, c[0]);
                expf = (64 >= fq) ? 256 : (256 * 64) / fq;
                exps = (256 * 64) / slow_quant(s);
                check($sformatf("R5 fast count s%0d cal%0d", s, c), cnt_fast, int'(expf));
                check($sformatf("R6 slow count s%0d cal%0d", s, c), cnt_slow, int'(exps));
            end
        end

        // R6: oversized samples in 2048x mode, one pulse per sample
        rate_sel_hi = 1; rate_sel_lo = 1; cal_sel = 0;
        do_reset();
        feed(5000, 100);
        check("R6 one fast pulse per sample", cnt_fast, 100);

        // R7/R8: reverse flag
        rate_sel_hi = 0; rate_sel_lo = 0; cal_sel = 1;
        do_reset();
        rev_flag = 1'b1;
        feed(300, 100);
        check("R7 no pulses while reverse", cnt_slow + cnt_fast, 0);
        check("R8 rev_out set at crossing", rev_out, 1);
        rev_flag = 1'b0;
        feed(0, 50);
        check("R8 rev_out holds without crossing", rev_out, 1);
        feed(300, 10);
        check("R8 rev_out cleared at crossing", rev_out, 0);
        check("R7 pulses resume", (cnt_fast > 0) ? 1 : 0, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule